// File: doc/BRIEF.md
# Microcontroller External Memory and Display Glue

This block sits in programmable logic between a small 8-bit microcontroller and a single 32 KB static RAM that holds both program code and data. The microcontroller shares one port between the low half of the address and the data byte. The block captures that low address byte while the address-latch strobe is high and keeps presenting it to the RAM after the port turns around to carry data. The high address byte from the second port goes straight through; only its lower seven bits reach the RAM.

The top address bit splits the external space. The lower half belongs to the RAM: chip enable follows that bit, and output enable is asserted for either a code fetch (program-store strobe) or a data read. The write strobe passes to the RAM write enable unchanged. The upper half of the external data space holds an output latch for a seven-segment display, loaded from the data byte when the write strobe returns high. The RAM stays deselected for any access there.

The block also owns the microcontroller reset and clock. After system reset it holds the microcontroller in reset for a programmable number of cycles. It passes the board clock through a glitch-free gate. A host isolate input takes the microcontroller and the RAM off the shared buses at once: it forces reset high and both RAM enables high.

Top module: `mcuMemGlue`

## Requirements
- R1: While `aleIn` is 1, `ramAddr[7:0]` equals `adBus` in the same cycle (the latch is transparent).
- R2: After `aleIn` falls, `ramAddr[7:0]` keeps the `adBus` value sampled at the last rising clock edge with `aleIn` high, whatever `adBus` then carries.
- R3: `ramAddr[14:8]` always equals `addrHi[6:0]`.
- R4: `ramCeN` is 0 exactly when `addrHi[7]` is 0 and `hostIsolate` is 0.
- R5: `ramOeN` is 0 exactly when at least one of `psenN` or `rdN` is 0 and `hostIsolate` is 0.
- R6: `ramWeN` equals `wrN` at all times.
- R7: `mcuRst` is 1 while `rstN` is 0 and for the first POR_CYCLES rising clock edges after `rstN` goes high. After that it is 1 only while `hostIsolate` is 1.
- R8: `hostIsolate` at 1 forces `mcuRst`, `ramCeN` and `ramOeN` to 1 in the same cycle, whatever the strobes and address are.
- R9: When `wrN` rises while `addrHi[7]` was 1, `segOut` takes the `adBus` byte present during the write low phase. The update is visible after the rising clock edge that first sees `wrN` high. Bits 6..0 drive segments S0..S6 and bit 7 drives the decimal point. The reset value is 0x00.
- R10: A write with `addrHi[7]` at 0, or one whose rising edge is seen while `hostIsolate` is 1, leaves `segOut` unchanged.
- R11: `mcuClk` follows `clk` while `mcuClkStop` is 0. Once `mcuClkStop` is 1 at a falling clock edge, `mcuClk` stays 0 from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board oscillator clock |
| rstN | input | 1 | Active-low system reset |
| hostIsolate | input | 1 | Host request to take the microcontroller and RAM off the buses |
| mcuClkStop | input | 1 | Stops the microcontroller clock at the next falling edge |
| adBus | input | 8 | Shared low-address / data port as seen by the glue |
| addrHi | input | 8 | High address byte from the microcontroller |
| aleIn | input | 1 | Address-latch strobe, active high |
| psenN | input | 1 | Program-store strobe, active low |
| rdN | input | 1 | Data read strobe, active low |
| wrN | input | 1 | Data write strobe, active low |
| ramAddr | output | 15 | RAM address lines |
| ramCeN | output | 1 | RAM chip enable, active low |
| ramOeN | output | 1 | RAM output enable, active low |
| ramWeN | output | 1 | RAM write enable, active low |
| mcuRst | output | 1 | Microcontroller reset, active high |
| mcuClk | output | 1 | Gated microcontroller clock |
| segOut | output | 8 | Display segments S0..S6 and decimal point |

## Verification
A display write and a host isolate request can land in the same cycle. The rising write strobe would load the latch, while isolation must block that load and also drive both RAM enables and reset high. The bench raises `hostIsolate` on the same falling edge that releases `wrN` after an upper-half write. It then checks that `segOut` kept its old byte and that reset, chip enable and output enable were all high in that cycle. A clean upper-half write afterwards confirms that the latch still loads once isolation drops.

// File: rtl/mcuGluePkg.sv
package mcuGluePkg;
  // Strobes the control half hands to the datapath every cycle
  typedef struct packed {
    logic captureLow;   // sample the shared port into the low-address register
    logic loadDisplay;  // load the sampled data byte into the display register
  } glueStrobes_t;
endpackage

// File: rtl/mcuGlueDatapath.sv
module mcuGlueDatapath
  import mcuGluePkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RAM_HI_W = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  glueStrobes_t               strobes,
  input  logic [DATA_W-1:0]          adBus,
  input  logic [RAM_HI_W-1:0]        addrHiRam,
  output logic [DATA_W+RAM_HI_W-1:0] ramAddr,
  output logic [DATA_W-1:0]          segOut
);
  logic [DATA_W-1:0] lowQ;
  logic [DATA_W-1:0] busQ;
  logic [DATA_W-1:0] lowNow;

  // Low-address register follows the port while the strobe is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowQ <= '0;
    else if (strobes.captureLow) lowQ <= adBus;
  end

  // Data byte sampled every cycle, so the value of the write low phase
  // is still available on the edge that sees the strobe return high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busQ <= '0;
    else busQ <= adBus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) segOut <= '0;
    else if (strobes.loadDisplay) segOut <= busQ;
  end

  // Transparent path while the strobe is high, held value otherwise
  always_comb begin
    lowNow  = strobes.captureLow ? adBus : lowQ;
    ramAddr = {addrHiRam, lowNow};
  end

  a_r2_low_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureLow |=> $stable(lowQ));
  a_r10_display_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadDisplay |=> $stable(segOut));
  a_r9_display_value: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadDisplay |=> (segOut == $past(busQ)));
endmodule

// File: rtl/mcuGlueControl.sv
module mcuGlueControl
  import mcuGluePkg::*;
#(
  parameter int POR_CYCLES = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostIsolate,
  input  logic         mcuClkStop,
  input  logic         aleIn,
  input  logic         psenN,
  input  logic         rdN,
  input  logic         wrN,
  input  logic         addrTop,
  output glueStrobes_t strobes,
  output logic         ramCeN,
  output logic         ramOeN,
  output logic         ramWeN,
  output logic         mcuRst,
  output logic         mcuClk
);
  localparam int POR_W = $clog2(POR_CYCLES + 1);
  localparam logic [POR_W-1:0] POR_END = POR_CYCLES[POR_W-1:0];

  logic [POR_W-1:0] porCount;
  logic             porActive;
  logic             wrPrev;
  logic             topQ;
  logic             gateRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) porCount <= '0;
    else if (porCount != POR_END) porCount <= porCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev <= 1'b1;
      topQ   <= 1'b0;
    end else begin
      wrPrev <= wrN;
      topQ   <= addrTop;
    end
  end

  // Gate enable changes only while the clock is low: no runt pulses
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) gateRun <= 1'b1;
    else gateRun <= !mcuClkStop;
  end

  always_comb begin
    porActive           = (porCount != POR_END);
    strobes.captureLow  = aleIn;
    strobes.loadDisplay = !wrPrev && wrN && topQ && !hostIsolate;
    ramCeN              = hostIsolate || addrTop;
    ramOeN              = hostIsolate || (psenN && rdN);
    ramWeN              = wrN;
    mcuRst              = hostIsolate || porActive;
    mcuClk              = clk && gateRun;
  end

  a_r8_isolate_forces: assert property (@(posedge clk) disable iff (!rstN)
    hostIsolate |-> (ramCeN && ramOeN && mcuRst));
  a_r7_reset_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mcuRst) |-> hostIsolate);
  a_r5_oe_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !ramOeN |-> (!psenN || !rdN));
  a_r4_ce_low_half: assert property (@(posedge clk) disable iff (!rstN)
    !ramCeN |-> !addrTop);
  a_r9_load_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadDisplay |-> (wrN && $past(!wrN)));
endmodule

// File: rtl/mcuMemGlue.sv
module mcuMemGlue
  import mcuGluePkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HI_W       = 8,
  parameter int POR_CYCLES = 24,
  localparam int RAM_HI_W  = HI_W - 1,
  localparam int RAM_AW    = DATA_W + RAM_HI_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostIsolate,
  input  logic              mcuClkStop,
  input  logic [DATA_W-1:0] adBus,
  input  logic [HI_W-1:0]   addrHi,
  input  logic              aleIn,
  input  logic              psenN,
  input  logic              rdN,
  input  logic              wrN,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramCeN,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic              mcuRst,
  output logic              mcuClk,
  output logic [DATA_W-1:0] segOut
);
  glueStrobes_t strobes;

  mcuGlueControl #(.POR_CYCLES(POR_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostIsolate(hostIsolate), .mcuClkStop(mcuClkStop),
    .aleIn(aleIn), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .addrTop(addrHi[HI_W-1]), .strobes(strobes),
    .ramCeN(ramCeN), .ramOeN(ramOeN), .ramWeN(ramWeN),
    .mcuRst(mcuRst), .mcuClk(mcuClk)
  );

  mcuGlueDatapath #(.DATA_W(DATA_W), .RAM_HI_W(RAM_HI_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .adBus(adBus),
    .addrHiRam(addrHi[RAM_HI_W-1:0]), .ramAddr(ramAddr), .segOut(segOut)
  );
endmodule

// File: tb/mcuMemGlue_tb.sv
module mcuMemGlue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int POR = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostIsolate = 1'b0, mcuClkStop = 1'b0;
  logic [7:0] adBus = '0, addrHi = '0;
  logic aleIn = 1'b0, psenN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [14:0] ramAddr;
  logic ramCeN, ramOeN, ramWeN, mcuRst, mcuClk;
  logic [7:0] segOut;

  int checks = 0;
  int fails = 0;
  logic [7:0] segExp = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcuMemGlue #(.POR_CYCLES(POR)) dut_i (
    .clk(clk), .rstN(rstN), .hostIsolate(hostIsolate), .mcuClkStop(mcuClkStop),
    .adBus(adBus), .addrHi(addrHi), .aleIn(aleIn), .psenN(psenN), .rdN(rdN),
    .wrN(wrN), .ramAddr(ramAddr), .ramCeN(ramCeN), .ramOeN(ramOeN),
    .ramWeN(ramWeN), .mcuRst(mcuRst), .mcuClk(mcuClk), .segOut(segOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Display write: strobe low for one rising edge, release on a falling edge
  task automatic extWrite(input logic [7:0] hi, input logic [7:0] data, input logic isoAtRise);
    @(negedge clk);
    addrHi = hi; adBus = data; wrN = 1'b0;
    #1 check("R6 we low", ramWeN, 0);
    @(negedge clk);
    wrN = 1'b1; hostIsolate = isoAtRise; adBus = ~data;
    #1;
    check("R6 we high", ramWeN, 1);
    if (isoAtRise) begin
      check("R8 rst at write rise", mcuRst, 1);
      check("R8 ce at write rise", ramCeN, 1);
      check("R8 oe at write rise", ramOeN, 1);
    end
    @(posedge clk); #1;
    if (hi[7] && !isoAtRise) segExp = data;
    check(hi[7] && !isoAtRise ? "R9 display load" : "R10 display unchanged", segOut, segExp);
    @(negedge clk); hostIsolate = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // Reset state
    #2;
    check("R7 rst during reset", mcuRst, 1);
    check("R9 seg reset", segOut, 0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    for (int k = 1; k <= POR + 2; k++) begin
      @(posedge clk); #1;
      check("R7 power-on hold", mcuRst, (k < POR) ? 1 : 0);
    end

    // R1 / R2: sweep all low-address values through the latch
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      aleIn = 1'b1; adBus = v[7:0];
      #1 check("R1 transparent", ramAddr[7:0], v);
      @(negedge clk);
      aleIn = 1'b0; adBus = ~v[7:0];
      #1 check("R2 hold after fall", ramAddr[7:0], v);
      @(posedge clk); #1;
      check("R2 hold next edge", ramAddr[7:0], v);
    end

    // R3 / R4 / R5 / R8: decode sweep over high byte, fetch/read strobes, isolate
    for (int h = 0; h < 256; h++) begin
      for (int s = 0; s < 8; s++) begin
        @(negedge clk);
        addrHi = h[7:0]; psenN = s[0]; rdN = s[1]; hostIsolate = s[2];
        #1;
        check("R3 high address", ramAddr[14:8], h & 8'h7f);
        check("R4 chip enable", ramCeN, (s[2] || h[7]) ? 1 : 0);
        check("R5 output enable", ramOeN, (s[2] || (s[0] && s[1])) ? 1 : 0);
        check("R8 reset by isolate", mcuRst, s[2] ? 1 : 0);
      end
    end
    @(negedge clk); hostIsolate = 1'b0; psenN = 1'b1; rdN = 1'b1;

    // R9 / R10: display writes in both halves, and isolate at the rising strobe
    for (int d = 0; d < 16; d++) begin
      extWrite(8'h80 | d[7:0], 8'h11 * d[7:0] ^ 8'h5a, 1'b0);
      extWrite(d[7:0] & 8'h7f, 8'hc3 ^ d[7:0], 1'b0);
    end
    extWrite(8'hff, 8'h81, 1'b0);
    extWrite(8'hc0, 8'h3e, 1'b1);
    check("R10 no load under isolate", segOut, 8'h81);
    extWrite(8'h80, 8'h7f, 1'b0);
    check("R9 load after isolate drops", segOut, 8'h7f);

    // R11: clock gate
    @(posedge clk); #1 check("R11 clock passes high", mcuClk, 1);
    @(negedge clk); #1 check("R11 clock passes low", mcuClk, 0);
    mcuClkStop = 1'b1;
    @(negedge clk);
    @(posedge clk); #1 check("R11 clock stopped", mcuClk, 0);
    @(posedge clk); #1 check("R11 clock stays stopped", mcuClk, 0);
    @(negedge clk); mcuClkStop = 1'b0;
    @(negedge clk);
    @(posedge clk); #1 check("R11 clock resumes", mcuClk, 1);

    finishRun();
  end
endmodule